// File: doc/BRIEF.md
# Event-Driven Gate Timing Simulation Engine

This block runs a transport-delay, event-driven timing simulation of a small netlist entirely in hardware. Each configured block is a two-input gate or a one-bit full adder. A block reads up to three nets from a node-state table and drives one or two output nets. Pending value changes are kept in a timing wheel. The wheel is a ring of per-time-step FIFOs, and the slot for a step is the simulated time modulo the ring size.

For each time step the engine does three things in order:
- It drains the events of the current step and writes each real change into the node table.
- It re-evaluates only the blocks that read a net that changed at that step.
- It schedules any changed block output into the slot at the current time plus a rise, fall or unknown-transition delay.

A host loads the block table, seeds stimulus events and starts a run. It watches every applied node change on a registered update port. It can read any node's value through a registered read port.

Top module: `evsim_core`

## Requirements
- R1: A block is evaluated at a step only if one of the nets it reads (input a and b; input c as well for the full adder) changed value at that step. Blocks whose inputs did not change keep their outputs and schedule nothing.
- R2: A block output event is scheduled only when the recomputed output differs from that output's stored value. Stored block outputs are X after the block is configured.
- R3: A scheduled event goes into the wheel slot at (current time + delay) mod 16. Events in one slot are applied in the order they were scheduled. Each applied change is reported on the update port with the step time.
- R4: The delay is the block's rise delay when the new value is 1, its fall delay when it is 0, and the larger of the two when it is X.
- R5: Node values use the 2-bit code 00 = 0, 01 = 1, 10 = X, 11 = Z. Every node is X after reset.
- R6: Function codes are 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 full adder. For AND/NAND a 0 input, and for OR/NOR a 1 input, decides the result even if the other input is X or Z. Otherwise any X or Z input gives X. NAND and NOR invert, and X stays X.
- R7: A full adder computes sum and carry of a, b and c, and any X or Z input makes both outputs X. The two outputs are compared and scheduled independently, with the sum scheduled before the carry.
- R8: A change on a net marks every block that reads it. The resulting output events land at a strictly later step.
- R9: Time advances by one only after the current slot is empty. A run ends, with done high and the time held, once every slot is empty.
- R10: A run also ends after the step whose time equals stop_time has been fully processed. A new start continues from that time with the events still pending.
- R11: Each slot holds 8 events. A push into a full slot is dropped and sets overflow, which stays high until reset.
- R12: An event whose value equals the node's present value changes nothing and produces no update report.
- R13: After reset busy, done, overflow, sim_time and upd_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one block table entry |
| cfg_blk | input | 2 | Block index |
| cfg_func | input | 3 | Function code |
| cfg_in_a | input | 4 | Input net a |
| cfg_in_b | input | 4 | Input net b |
| cfg_in_c | input | 4 | Carry-in net (full adder only) |
| cfg_out_s | input | 4 | Output net (sum for the adder) |
| cfg_out_c | input | 4 | Carry output net |
| cfg_rise | input | 4 | Delay to a 1 |
| cfg_fall | input | 4 | Delay to a 0 |
| seed_we | input | 1 | Schedule a stimulus event (idle only) |
| seed_node | input | 4 | Stimulus net |
| seed_val | input | 2 | Stimulus value |
| seed_delay | input | 4 | Offset from current time, 0 to 15 |
| start | input | 1 | Begin a run |
| stop_time | input | 16 | Last step to process in this run |
| rd_node | input | 4 | Node to read |
| rd_val | output | 2 | Registered node value |
| upd_valid | output | 1 | A node changed |
| upd_node | output | 4 | Changed node |
| upd_val | output | 2 | New value |
| upd_time | output | 16 | Step of the change |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| sim_time | output | 16 | Current simulated time |
| overflow | output | 1 | Sticky slot-full flag |

## Verification
The assertions assume the host writes the block table and seeds events only while the engine is idle. They also assume every configured rise and fall delay lies between 1 and 15, so a block never schedules into the slot being drained. They further assume stop_time is not below the time at which a run starts. The stimulus keeps within these limits by configuring and seeding only between runs, using delays of 1 to 6 for blocks, and always passing a stop time at or beyond the current step. The overflow test places nine events in one slot through the seed port. This keeps the drop case away from block scheduling.

// File: rtl/evsim_pkg.sv
package evsim_pkg;
  localparam logic [1:0] LV_0 = 2'b00;
  localparam logic [1:0] LV_1 = 2'b01;
  localparam logic [1:0] LV_X = 2'b10;
  localparam logic [1:0] LV_Z = 2'b11;

  localparam logic [2:0] FN_AND  = 3'd0;
  localparam logic [2:0] FN_OR   = 3'd1;
  localparam logic [2:0] FN_XOR  = 3'd2;
  localparam logic [2:0] FN_NAND = 3'd3;
  localparam logic [2:0] FN_NOR  = 3'd4;
  localparam logic [2:0] FN_FA   = 3'd5;

  // X and Z both have the upper code bit set
  function automatic logic lv_known(logic [1:0] v);
    return !v[1];
  endfunction

  function automatic logic [1:0] lv_inv(logic [1:0] v);
    return lv_known(v) ? {1'b0, ~v[0]} : LV_X;
  endfunction

  function automatic logic [1:0] lv_and(logic [1:0] a, logic [1:0] b);
    if (a == LV_0 || b == LV_0) return LV_0;
    if (lv_known(a) && lv_known(b)) return LV_1;
    return LV_X;
  endfunction

  function automatic logic [1:0] lv_or(logic [1:0] a, logic [1:0] b);
    if (a == LV_1 || b == LV_1) return LV_1;
    if (lv_known(a) && lv_known(b)) return LV_0;
    return LV_X;
  endfunction

  function automatic logic [1:0] lv_xor(logic [1:0] a, logic [1:0] b);
    if (lv_known(a) && lv_known(b)) return {1'b0, a[0] ^ b[0]};
    return LV_X;
  endfunction
endpackage

// File: rtl/evsim_eval.sv
module evsim_eval
  import evsim_pkg::*;
(
  input  logic [2:0] func,
  input  logic [1:0] a,
  input  logic [1:0] b,
  input  logic [1:0] c,
  output logic [1:0] y_sum,
  output logic [1:0] y_carry
);
  logic [1:0] and_ab;
  logic [1:0] or_ab;
  logic       all_known;

  always_comb begin
    and_ab    = lv_and(a, b);
    or_ab     = lv_or(a, b);
    all_known = lv_known(a) && lv_known(b) && lv_known(c);
    y_carry   = LV_X;
    case (func)
      FN_AND:  y_sum = and_ab;
      FN_OR:   y_sum = or_ab;
      FN_XOR:  y_sum = lv_xor(a, b);
      FN_NAND: y_sum = lv_inv(and_ab);
      FN_NOR:  y_sum = lv_inv(or_ab);
      FN_FA: begin
        if (all_known) begin
          y_sum   = {1'b0, a[0] ^ b[0] ^ c[0]};
          y_carry = {1'b0, (a[0] & b[0]) | (a[0] & c[0]) | (b[0] & c[0])};
        end else begin
          y_sum   = LV_X;
        end
      end
      default: y_sum = LV_X;
    endcase
  end
endmodule

// File: rtl/evsim_wheel.sv
module evsim_wheel #(
  parameter int SLOTS = 16,
  parameter int DEPTH = 8,
  parameter int EW    = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [$clog2(SLOTS)-1:0] push_slot,
  input  logic [EW-1:0]            push_data,
  input  logic                     pop,
  input  logic [$clog2(SLOTS)-1:0] pop_slot,
  output logic [EW-1:0]            head_data,
  output logic                     head_empty,
  output logic                     all_empty,
  output logic                     ovf
);
  localparam int SW = $clog2(SLOTS);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem [SLOTS*DEPTH];
  logic [PW-1:0] wp  [SLOTS];
  logic [PW-1:0] rp  [SLOTS];
  logic [CW-1:0] cnt [SLOTS];
  logic          push_ok;
  logic          pop_ok;

  assign push_ok    = push && (cnt[push_slot] != CW'(DEPTH));
  assign pop_ok     = pop && (cnt[pop_slot] != '0);
  assign head_data  = mem[{pop_slot, rp[pop_slot]}];
  assign head_empty = (cnt[pop_slot] == '0);

  always_comb begin
    all_empty = 1'b1;
    for (int s = 0; s < SLOTS; s++)
      if (cnt[s] != '0) all_empty = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[{push_slot, wp[push_slot]}] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf <= 1'b0;
      for (int s = 0; s < SLOTS; s++) begin
        wp[s]  <= '0;
        rp[s]  <= '0;
        cnt[s] <= '0;
      end
    end else begin
      if (push && !push_ok) ovf <= 1'b1;
      if (push_ok) wp[push_slot] <= wp[push_slot] + 1'b1;
      if (pop_ok)  rp[pop_slot]  <= rp[pop_slot] + 1'b1;
      for (int s = 0; s < SLOTS; s++)
        cnt[s] <= cnt[s] + CW'(push_ok && (push_slot == SW'(s)))
                         - CW'(pop_ok && (pop_slot == SW'(s)));
    end
  end

  a_r11_full_sets_ovf: assert property (@(posedge clk) disable iff (rst)
    (push && cnt[push_slot] == CW'(DEPTH)) |=> ovf);
  a_r11_full_drops: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && cnt[push_slot] == CW'(DEPTH)) |=> (cnt[$past(push_slot)] == CW'(DEPTH)));
endmodule

// File: rtl/evsim_core.sv
module evsim_core
  import evsim_pkg::*;
#(
  parameter int NODES  = 16,
  parameter int BLOCKS = 4,
  parameter int SLOTS  = 16,
  parameter int DEPTH  = 8,
  parameter int DLY_W  = 4,
  parameter int TIME_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [$clog2(BLOCKS)-1:0]  cfg_blk,
  input  logic [2:0]                 cfg_func,
  input  logic [$clog2(NODES)-1:0]   cfg_in_a,
  input  logic [$clog2(NODES)-1:0]   cfg_in_b,
  input  logic [$clog2(NODES)-1:0]   cfg_in_c,
  input  logic [$clog2(NODES)-1:0]   cfg_out_s,
  input  logic [$clog2(NODES)-1:0]   cfg_out_c,
  input  logic [DLY_W-1:0]           cfg_rise,
  input  logic [DLY_W-1:0]           cfg_fall,
  input  logic                       seed_we,
  input  logic [$clog2(NODES)-1:0]   seed_node,
  input  logic [1:0]                 seed_val,
  input  logic [DLY_W-1:0]           seed_delay,
  input  logic                       start,
  input  logic [TIME_W-1:0]          stop_time,
  input  logic [$clog2(NODES)-1:0]   rd_node,
  output logic [1:0]                 rd_val,
  output logic                       upd_valid,
  output logic [$clog2(NODES)-1:0]   upd_node,
  output logic [1:0]                 upd_val,
  output logic [TIME_W-1:0]          upd_time,
  output logic                       busy,
  output logic                       done,
  output logic [TIME_W-1:0]          sim_time,
  output logic                       overflow
);
  localparam int NW = $clog2(NODES);
  localparam int BW = $clog2(BLOCKS);
  localparam int SW = $clog2(SLOTS);
  localparam int EW = NW + 2;
  localparam int IW = BW + 1;
  localparam logic [IW-1:0] IDX_LAST = IW'(2 * BLOCKS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_POP, ST_EVAL, ST_ADV} st_t;
  st_t st;

  // block table: configuration (no reset) and run state (reset)
  logic [2:0]       blk_fn   [BLOCKS];
  logic [NW-1:0]    blk_a    [BLOCKS];
  logic [NW-1:0]    blk_b    [BLOCKS];
  logic [NW-1:0]    blk_c    [BLOCKS];
  logic [NW-1:0]    blk_os   [BLOCKS];
  logic [NW-1:0]    blk_oc   [BLOCKS];
  logic [DLY_W-1:0] blk_rise [BLOCKS];
  logic [DLY_W-1:0] blk_fall [BLOCKS];
  logic [BLOCKS-1:0] blk_vld;
  logic [1:0]       blk_qs   [BLOCKS];
  logic [1:0]       blk_qc   [BLOCKS];
  logic [1:0]       node_q   [NODES];
  logic [BLOCKS-1:0] pend;
  logic [BLOCKS-1:0] reads_ev;
  logic [IW-1:0]    idx;

  // wheel interface
  logic          w_push, w_pop, w_head_empty, w_all_empty;
  logic [SW-1:0] w_push_slot, cur_slot;
  logic [EW-1:0] w_push_data, w_head;
  logic [NW-1:0] ev_node;
  logic [1:0]    ev_val;

  // evaluation path
  logic [BW-1:0]    cur_blk;
  logic             cur_sel;
  logic [1:0]       y_sum, y_carry, new_v, old_v;
  logic [DLY_W-1:0] dly;
  logic             want;

  assign cur_slot = sim_time[SW-1:0];
  assign cur_blk  = idx[IW-1:1];
  assign cur_sel  = idx[0];
  assign {ev_node, ev_val} = w_head;

  evsim_eval u_eval (
    .func    (blk_fn[cur_blk]),
    .a       (node_q[blk_a[cur_blk]]),
    .b       (node_q[blk_b[cur_blk]]),
    .c       (node_q[blk_c[cur_blk]]),
    .y_sum   (y_sum),
    .y_carry (y_carry)
  );

  always_comb begin
    new_v = cur_sel ? y_carry : y_sum;
    old_v = cur_sel ? blk_qc[cur_blk] : blk_qs[cur_blk];
    want  = (st == ST_EVAL) && pend[cur_blk] && blk_vld[cur_blk] &&
            (!cur_sel || blk_fn[cur_blk] == FN_FA) && (new_v != old_v);
    if (new_v == LV_1)      dly = blk_rise[cur_blk];
    else if (new_v == LV_0) dly = blk_fall[cur_blk];
    else dly = (blk_rise[cur_blk] > blk_fall[cur_blk]) ? blk_rise[cur_blk] : blk_fall[cur_blk];
  end

  // which blocks read the net of the event at the head of the slot
  for (genvar g = 0; g < BLOCKS; g++) begin : g_fanout
    assign reads_ev[g] = blk_vld[g] &&
      (blk_a[g] == ev_node || blk_b[g] == ev_node ||
       (blk_fn[g] == FN_FA && blk_c[g] == ev_node));
  end

  always_comb begin
    if (st == ST_IDLE) begin
      w_push      = seed_we;
      w_push_slot = cur_slot + SW'(seed_delay);
      w_push_data = {seed_node, seed_val};
    end else begin
      w_push      = want;
      w_push_slot = cur_slot + SW'(dly);
      w_push_data = {cur_sel ? blk_oc[cur_blk] : blk_os[cur_blk], new_v};
    end
    w_pop = (st == ST_POP) && !w_head_empty;
  end

  evsim_wheel #(.SLOTS(SLOTS), .DEPTH(DEPTH), .EW(EW)) u_wheel (
    .clk        (clk),
    .rst        (rst),
    .push       (w_push),
    .push_slot  (w_push_slot),
    .push_data  (w_push_data),
    .pop        (w_pop),
    .pop_slot   (cur_slot),
    .head_data  (w_head),
    .head_empty (w_head_empty),
    .all_empty  (w_all_empty),
    .ovf        (overflow)
  );

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      blk_fn[cfg_blk]   <= cfg_func;
      blk_a[cfg_blk]    <= cfg_in_a;
      blk_b[cfg_blk]    <= cfg_in_b;
      blk_c[cfg_blk]    <= cfg_in_c;
      blk_os[cfg_blk]   <= cfg_out_s;
      blk_oc[cfg_blk]   <= cfg_out_c;
      blk_rise[cfg_blk] <= cfg_rise;
      blk_fall[cfg_blk] <= cfg_fall;
    end
  end

  always_ff @(posedge clk) begin
    rd_val <= node_q[rd_node];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      sim_time  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      upd_valid <= 1'b0;
      upd_node  <= '0;
      upd_val   <= LV_X;
      upd_time  <= '0;
      pend      <= '0;
      idx       <= '0;
      blk_vld   <= '0;
      for (int b = 0; b < BLOCKS; b++) begin
        blk_qs[b] <= LV_X;
        blk_qc[b] <= LV_X;
      end
      for (int n = 0; n < NODES; n++) node_q[n] <= LV_X;
    end else begin
      upd_valid <= 1'b0;
      if (cfg_we) begin
        blk_vld[cfg_blk] <= 1'b1;
        blk_qs[cfg_blk]  <= LV_X;
        blk_qc[cfg_blk]  <= LV_X;
      end
      case (st)
        ST_IDLE: if (start) begin
          st   <= ST_POP;
          busy <= 1'b1;
          done <= 1'b0;
        end
        ST_POP: begin
          if (w_head_empty) begin
            st  <= ST_EVAL;
            idx <= '0;
          end else if (ev_val != node_q[ev_node]) begin
            node_q[ev_node] <= ev_val;
            pend      <= pend | reads_ev;
            upd_valid <= 1'b1;
            upd_node  <= ev_node;
            upd_val   <= ev_val;
            upd_time  <= sim_time;
          end
        end
        ST_EVAL: begin
          if (want) begin
            if (cur_sel) blk_qc[cur_blk] <= new_v;
            else         blk_qs[cur_blk] <= new_v;
          end
          if (idx == IDX_LAST) begin
            pend <= '0;
            st   <= ST_ADV;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: begin
          if (w_all_empty || sim_time == stop_time) begin
            st   <= ST_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            sim_time <= sim_time + 1'b1;
            st       <= ST_POP;
          end
        end
      endcase
    end
  end

  a_r9_adv_slot_drained: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ADV) |-> w_head_empty);
  a_r3_block_event_future: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EVAL && w_push) |-> (w_push_slot != cur_slot));
  a_r10_stop_halts: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ADV && sim_time == stop_time) |=> (st == ST_IDLE && $stable(sim_time)));
  a_r13_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  a_r12_upd_is_change: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> (node_q[upd_node] == upd_val));
  a_r8_eval_only_fanout: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (pend == '0));
endmodule

// File: tb/evsim_core_tb.sv
module evsim_core_tb_top;
  import evsim_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       cfg_we = 0;
  logic [1:0] cfg_blk = 0;
  logic [2:0] cfg_func = 0;
  logic [3:0] cfg_in_a = 0, cfg_in_b = 0, cfg_in_c = 0, cfg_out_s = 0, cfg_out_c = 0;
  logic [3:0] cfg_rise = 0, cfg_fall = 0;
  logic       seed_we = 0;
  logic [3:0] seed_node = 0;
  logic [1:0] seed_val = 0;
  logic [3:0] seed_delay = 0;
  logic       start = 0;
  logic [15:0] stop_time = 16'hFFFF;
  logic [3:0] rd_node = 0;
  logic [1:0] rd_val;
  logic       upd_valid;
  logic [3:0] upd_node;
  logic [1:0] upd_val;
  logic [15:0] upd_time;
  logic       busy, done, overflow;
  logic [15:0] sim_time;

  evsim_core dut_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_blk(cfg_blk), .cfg_func(cfg_func),
    .cfg_in_a(cfg_in_a), .cfg_in_b(cfg_in_b), .cfg_in_c(cfg_in_c),
    .cfg_out_s(cfg_out_s), .cfg_out_c(cfg_out_c),
    .cfg_rise(cfg_rise), .cfg_fall(cfg_fall),
    .seed_we(seed_we), .seed_node(seed_node), .seed_val(seed_val), .seed_delay(seed_delay),
    .start(start), .stop_time(stop_time),
    .rd_node(rd_node), .rd_val(rd_val),
    .upd_valid(upd_valid), .upd_node(upd_node), .upd_val(upd_val), .upd_time(upd_time),
    .busy(busy), .done(done), .sim_time(sim_time), .overflow(overflow)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [21:0] exp_q [$];   // {time, node, value}

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_upd(input int t, input int n, input logic [1:0] v);
    exp_q.push_back({16'(t), 4'(n), v});
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst && upd_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 unexpected update actual=%0h expected=none", {upd_time, upd_node, upd_val});
      end else begin
        check("R3 update order/time", {10'd0, upd_time, upd_node, upd_val}, {10'd0, exp_q.pop_front()});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cfg(input int b, input logic [2:0] f, input int a, input int bb, input int c,
                     input int os, input int oc, input int r, input int fl);
    @(negedge clk);
    cfg_we = 1; cfg_blk = 2'(b); cfg_func = f;
    cfg_in_a = 4'(a); cfg_in_b = 4'(bb); cfg_in_c = 4'(c);
    cfg_out_s = 4'(os); cfg_out_c = 4'(oc); cfg_rise = 4'(r); cfg_fall = 4'(fl);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic seed(input int n, input logic [1:0] v, input int d);
    @(negedge clk);
    seed_we = 1; seed_node = 4'(n); seed_val = v; seed_delay = 4'(d);
    @(negedge clk);
    seed_we = 0;
  endtask

  task automatic run_sim(input logic [15:0] st);
    @(negedge clk);
    stop_time = st; start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_node(input int n, input logic [1:0] exp, input string req);
    @(negedge clk);
    rd_node = 4'(n);
    @(negedge clk);
    check(req, 32'(rd_val), 32'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R13 reset state
    check("R13 busy", 32'(busy), 0);
    check("R13 done", 32'(done), 0);
    check("R13 overflow", 32'(overflow), 0);
    check("R13 sim_time", 32'(sim_time), 0);
    read_node(0, LV_X, "R5 node X after reset");

    cfg(0, FN_AND, 0, 1, 0, 4, 0, 3, 5);
    cfg(1, FN_XOR, 4, 2, 0, 5, 0, 2, 2);
    cfg(2, FN_FA,  0, 1, 2, 6, 7, 4, 6);
    cfg(3, FN_NOR, 8, 9, 0, 10, 0, 1, 2);

    // scenario 1: known inputs, rise/fall, fanout, adder split (R1 R2 R4 R7 R8)
    seed(0, LV_1, 0); seed(1, LV_1, 0); seed(2, LV_0, 0);
    expect_upd(0, 0, LV_1); expect_upd(0, 1, LV_1); expect_upd(0, 2, LV_0);
    expect_upd(3, 4, LV_1);  // R4 rise 3
    expect_upd(4, 7, LV_1);  // R7 carry rise 4
    expect_upd(5, 5, LV_1);  // R8 fanout of net 4
    expect_upd(6, 6, LV_0);  // R7 sum fall 6
    run_sim(16'hFFFF);
    check("R9 end time", 32'(sim_time), 6);
    check("R9 done", 32'(done), 1);
    check("R3 all updates seen", exp_q.size(), 0);
    read_node(10, LV_X, "R1 untouched block output");
    read_node(5, LV_1, "R8 xor output");
    read_node(6, LV_0, "R7 adder sum");

    // scenario 2: X input, controlling 0, max delay (R4 R6 R7)
    seed(1, LV_X, 1); seed(0, LV_0, 3);
    expect_upd(7, 1, LV_X);
    expect_upd(9, 0, LV_0);
    expect_upd(12, 4, LV_X);  // R4 max(3,5)
    expect_upd(13, 6, LV_X);  // R7 sum before carry
    expect_upd(13, 7, LV_X);
    expect_upd(14, 4, LV_0);  // R6 controlling 0
    expect_upd(14, 5, LV_X);
    expect_upd(16, 5, LV_0);
    run_sim(16'hFFFF);
    check("R9 end time 2", 32'(sim_time), 16);
    check("R3 all updates seen 2", exp_q.size(), 0);

    // scenario 3: NOR with Z input (R5 R6)
    seed(8, LV_1, 1); seed(9, LV_Z, 1);
    expect_upd(17, 8, LV_1); expect_upd(17, 9, LV_Z);
    expect_upd(19, 10, LV_0);  // R6 controlling 1 beats Z
    run_sim(16'hFFFF);
    seed(8, LV_0, 1);
    expect_upd(20, 8, LV_0);
    expect_upd(22, 10, LV_X);  // R6 Z gives X, R4 max(1,2)
    run_sim(16'hFFFF);
    read_node(9, LV_Z, "R5 Z code");
    check("R3 all updates seen 3", exp_q.size(), 0);

    // scenario 4: stop time (R10)
    seed(8, LV_1, 1);
    expect_upd(23, 8, LV_1);
    run_sim(16'd23);
    check("R10 stopped time", 32'(sim_time), 23);
    check("R10 no busy", 32'(busy), 0);
    read_node(10, LV_X, "R10 pending not applied");
    expect_upd(25, 10, LV_0);
    run_sim(16'hFFFF);
    check("R10 resumed time", 32'(sim_time), 25);

    // scenario 5: overflow and repeated values (R11 R12)
    check("R11 overflow before", 32'(overflow), 0);
    seed(11, LV_1, 1); seed(11, LV_1, 1); seed(11, LV_0, 1); seed(11, LV_0, 1);
    seed(11, LV_1, 1); seed(11, LV_1, 1); seed(11, LV_0, 1); seed(11, LV_0, 1);
    seed(11, LV_1, 1);
    check("R11 overflow set", 32'(overflow), 1);
    expect_upd(26, 11, LV_1); expect_upd(26, 11, LV_0);
    expect_upd(26, 11, LV_1); expect_upd(26, 11, LV_0);
    run_sim(16'hFFFF);
    read_node(11, LV_0, "R11 ninth event dropped");
    check("R11 overflow sticky", 32'(overflow), 1);
    check("R12 all updates seen", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule